// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block turns a write to a processor's interrupt command register into one delivery action aimed at a set of target processors. Software writes the high command word first. That word holds the destination and is only stored. Software then writes the low command word, which starts a dispatch. While the dispatch is busy, the block presents the stored destination and the destination-mode bit to an upstream matcher. It then takes that matcher's per-target match mask back in the same cycle. The block applies the destination shorthand to form the final target set. On the next cycle it emits a one-cycle pulse on exactly one per-target action vector, chosen by the delivery mode.

The per-target interrupt state lives outside the block. Targets capture the shared vector and trigger outputs on the cycle their pulse is high. When extended addressing is active, a dedicated self-interrupt write also starts a dispatch. It carries only a vector and is sent to the sender alone, as an edge-triggered fixed interrupt.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset, busy_o and every per-target pulse output are 0.
- R2: A low-word write sets busy_o for exactly the next cycle, and the action pulses appear in the cycle after that. A high-word write alone only stores the word and never sets busy_o.
- R3: While busy_o is 1, dest_o shows the stored high word and dest_logical_o shows command bit 11. In compact mode (ext_mode_i=0), dest_o carries high-word bits [31:24] in its low byte with zeros above. In extended mode, dest_o is the full 32-bit high word.
- R4: The target set comes from the shorthand in command bits [19:18]. Value 0 uses match_mask_i, 1 uses only the target at self_idx_i, 2 uses every target, and 3 uses every target except self_idx_i.
- R5: Delivery mode is command bits [10:8]. Mode 0 (fixed) pulses fixed_set_o on the target set. On every dispatch, vec_o takes command bits [7:0] and trig_o takes command bit 15.
- R6: Mode 1 (lowest priority) pulses fixed_set_o only on the lowest-numbered target in the set. With an empty set it pulses nothing.
- R7: Mode 2 pulses smi_o on the target set, and mode 4 pulses nmi_o on the target set.
- R8: Mode 5 (INIT) pulses init_o on the target set unless level (bit 14) is 0 and trigger (bit 15) is 1.
- R9: INIT with level 0 and trigger 1 pulses arb_reload_o on the target set and leaves init_o at 0.
- R10: Mode 6 (startup) pulses sipi_o on the target set, with the command vector on vec_o.
- R11: Modes 3 and 7 are reserved and pulse no output.
- R12: In extended mode, a self-interrupt write dispatches a fixed, edge-triggered (trig_o=0) interrupt with vector wr_data_i[7:0] to the self target only. In compact mode, that write is ignored: no busy_o and no pulse follow.
- R13: Each action pulse lasts one cycle and appears only in the cycle after busy_o. Within one dispatch, at most one of the six pulse vectors is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | 1 selects extended (32-bit) destination addressing |
| wr_lo_i | input | 1 | Write strobe for the low command word; starts a dispatch |
| wr_hi_i | input | 1 | Write strobe for the high command word (destination) |
| wr_self_i | input | 1 | Write strobe for the self-interrupt register (extended mode only) |
| wr_data_i | input | 32 | Write data for all three strobes |
| self_idx_i | input | IDX_W | Index of the sending processor among the targets |
| match_mask_i | input | N_TGT | Destination match mask from the upstream matcher, sampled while busy |
| dest_o | output | 32 | Destination presented to the upstream matcher |
| dest_logical_o | output | 1 | Destination mode presented to the matcher (1 = logical) |
| busy_o | output | 1 | High for the one cycle in which the dispatch is resolved |
| fixed_set_o | output | N_TGT | Per-target fixed-vector set pulse (fixed and lowest-priority modes) |
| smi_o | output | N_TGT | Per-target SMI request pulse |
| nmi_o | output | N_TGT | Per-target NMI request pulse |
| init_o | output | N_TGT | Per-target INIT request pulse |
| sipi_o | output | N_TGT | Per-target startup request pulse |
| arb_reload_o | output | N_TGT | Per-target arbitration-ID reload pulse |
| vec_o | output | 8 | Vector of the latest dispatch |
| trig_o | output | 1 | Trigger mode of the latest dispatch (1 = level) |

## Verification
The checker watches several properties on every cycle. busy_o follows only a low-word write or an extended-mode self write, and a pulse never appears except right after busy_o. No two action classes fire together, and compact-mode destinations never show bits above the low byte. Only the bench's directed and random scenarios can show that each pulse lands on the right targets:
- the shorthand overrides of the match mask,
- the lowest-numbered pick,
- the INIT level-deassert split,
- the silence of reserved modes and of compact-mode self writes.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD3  = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_RSVD7  = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vec;
    dmode_e     mode;
    logic       logical;
    logic       level;
    logic       trig;
    shorthand_e sh;
  } cmd_t;

  function automatic cmd_t decode_lo(logic [31:0] w);
    cmd_t c;
    c.vec     = w[7:0];
    c.mode    = dmode_e'(w[10:8]);
    c.logical = w[11];
    c.level   = w[14];
    c.trig    = w[15];
    c.sh      = shorthand_e'(w[19:18]);
    return c;
  endfunction

  function automatic cmd_t self_cmd(logic [7:0] v);
    cmd_t c;
    c.vec     = v;
    c.mode    = DM_FIXED;
    c.logical = 1'b0;
    c.level   = 1'b1;
    c.trig    = 1'b0;
    c.sh      = SH_SELF;
    return c;
  endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ext_mode_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic        wr_self_i,
  input  logic [31:0] wr_data_i,
  output cmd_t        cmd_o,
  output logic [31:0] hi_o,
  output logic        pend_o
);

  cmd_t        cmd_q;
  logic [31:0] hi_q;
  logic        pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_hi_i) hi_q <= wr_data_i;
      // low word has priority over a same-cycle self write
      if (wr_lo_i) begin
        cmd_q  <= decode_lo(wr_data_i);
        pend_q <= 1'b1;
      end else if (wr_self_i && ext_mode_i) begin
        cmd_q  <= self_cmd(wr_data_i[7:0]);
        pend_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign hi_o   = hi_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/ipi_tgt_mask.sv
module ipi_tgt_mask
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  shorthand_e       sh_i,
  input  logic [N_TGT-1:0] match_i,
  input  logic [IDX_W-1:0] self_idx_i,
  output logic [N_TGT-1:0] tgt_o,
  output logic [N_TGT-1:0] first_o
);

  logic [N_TGT-1:0] self_oh;
  logic [N_TGT-1:0] seen;

  always_comb begin
    self_oh = '0;
    self_oh[self_idx_i] = 1'b1;
  end

  always_comb begin
    unique case (sh_i)
      SH_NONE:   tgt_o = match_i;
      SH_SELF:   tgt_o = self_oh;
      SH_ALL:    tgt_o = '1;
      SH_OTHERS: tgt_o = ~self_oh;
      default:   tgt_o = '0;
    endcase
  end

  // lowest-numbered set bit via a carry chain
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N_TGT; i++) begin : g_first
    assign first_o[i] = tgt_o[i] & ~seen[i];
    if (i < N_TGT - 1) begin : g_chain
      assign seen[i+1] = seen[i] | tgt_o[i];
    end
  end

endmodule

// File: rtl/ipi_action_dec.sv
module ipi_action_dec
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  dmode_e           mode_i,
  input  logic             level_i,
  input  logic             trig_i,
  input  logic [7:0]       vec_i,
  input  logic [N_TGT-1:0] tgt_i,
  input  logic [N_TGT-1:0] first_i,
  output logic [N_TGT-1:0] fixed_o,
  output logic [N_TGT-1:0] smi_o,
  output logic [N_TGT-1:0] nmi_o,
  output logic [N_TGT-1:0] init_o,
  output logic [N_TGT-1:0] sipi_o,
  output logic [N_TGT-1:0] arb_o,
  output logic [7:0]       vec_o,
  output logic             trig_o
);

  logic [N_TGT-1:0] fixed_n, smi_n, nmi_n, init_n, sipi_n, arb_n;
  logic             deassert;

  assign deassert = !level_i && trig_i;

  always_comb begin
    fixed_n = '0;
    smi_n   = '0;
    nmi_n   = '0;
    init_n  = '0;
    sipi_n  = '0;
    arb_n   = '0;
    if (fire_i) begin
      unique case (mode_i)
        DM_FIXED:  fixed_n = tgt_i;
        DM_LOWEST: fixed_n = first_i;
        DM_SMI:    smi_n   = tgt_i;
        DM_NMI:    nmi_n   = tgt_i;
        DM_INIT: begin
          if (deassert) arb_n  = tgt_i;
          else          init_n = tgt_i;
        end
        DM_START:  sipi_n  = tgt_i;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fixed_o <= '0;
      smi_o   <= '0;
      nmi_o   <= '0;
      init_o  <= '0;
      sipi_o  <= '0;
      arb_o   <= '0;
      vec_o   <= '0;
      trig_o  <= 1'b0;
    end else begin
      fixed_o <= fixed_n;
      smi_o   <= smi_n;
      nmi_o   <= nmi_n;
      init_o  <= init_n;
      sipi_o  <= sipi_n;
      arb_o   <= arb_n;
      if (fire_i) begin
        vec_o  <= vec_i;
        trig_o <= trig_i;
      end
    end
  end

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_self_i,
  input  logic [31:0]      wr_data_i,
  input  logic [IDX_W-1:0] self_idx_i,
  input  logic [N_TGT-1:0] match_mask_i,
  output logic [31:0]      dest_o,
  output logic             dest_logical_o,
  output logic             busy_o,
  output logic [N_TGT-1:0] fixed_set_o,
  output logic [N_TGT-1:0] smi_o,
  output logic [N_TGT-1:0] nmi_o,
  output logic [N_TGT-1:0] init_o,
  output logic [N_TGT-1:0] sipi_o,
  output logic [N_TGT-1:0] arb_reload_o,
  output logic [7:0]       vec_o,
  output logic             trig_o
);

  cmd_t             cmd;
  logic [31:0]      hi_w;
  logic             pend;
  logic [N_TGT-1:0] tgt, first;

  ipi_cmd_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .wr_lo_i    (wr_lo_i),
    .wr_hi_i    (wr_hi_i),
    .wr_self_i  (wr_self_i),
    .wr_data_i  (wr_data_i),
    .cmd_o      (cmd),
    .hi_o       (hi_w),
    .pend_o     (pend)
  );

  assign dest_o         = ext_mode_i ? hi_w : {24'h0, hi_w[31:24]};
  assign dest_logical_o = cmd.logical;
  assign busy_o         = pend;

  ipi_tgt_mask #(.N_TGT(N_TGT)) u_mask (
    .sh_i       (cmd.sh),
    .match_i    (match_mask_i),
    .self_idx_i (self_idx_i),
    .tgt_o      (tgt),
    .first_o    (first)
  );

  ipi_action_dec #(.N_TGT(N_TGT)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (pend),
    .mode_i  (cmd.mode),
    .level_i (cmd.level),
    .trig_i  (cmd.trig),
    .vec_i   (cmd.vec),
    .tgt_i   (tgt),
    .first_i (first),
    .fixed_o (fixed_set_o),
    .smi_o   (smi_o),
    .nmi_o   (nmi_o),
    .init_o  (init_o),
    .sipi_o  (sipi_o),
    .arb_o   (arb_reload_o),
    .vec_o   (vec_o),
    .trig_o  (trig_o)
  );

endmodule

// File: rtl/ipi_cmd_dispatch_chk.sv
module ipi_cmd_dispatch_chk #(
  parameter int N_TGT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_mode_i,
  input logic             wr_lo_i,
  input logic             wr_self_i,
  input logic             busy_o,
  input logic [31:0]      dest_o,
  input logic [N_TGT-1:0] fixed_set_o,
  input logic [N_TGT-1:0] smi_o,
  input logic [N_TGT-1:0] nmi_o,
  input logic [N_TGT-1:0] init_o,
  input logic [N_TGT-1:0] sipi_o,
  input logic [N_TGT-1:0] arb_reload_o
);

  logic any_pulse;
  assign any_pulse = |{fixed_set_o, smi_o, nmi_o, init_o, sipi_o, arb_reload_o};

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $past(wr_lo_i || (wr_self_i && ext_mode_i))); // R2

  AST_PULSE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |-> $past(busy_o)); // R13

  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|fixed_set_o, |smi_o, |nmi_o, |init_o, |sipi_o, |arb_reload_o})); // R13

  AST_COMPACT_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ext_mode_i) |-> (dest_o[31:8] == 24'h0)); // R3

  AST_INIT_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arb_reload_o) |-> (init_o == '0)); // R9

endmodule

bind ipi_cmd_dispatch ipi_cmd_dispatch_chk #(.N_TGT(N_TGT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ext_mode_i   (ext_mode_i),
  .wr_lo_i      (wr_lo_i),
  .wr_self_i    (wr_self_i),
  .busy_o       (busy_o),
  .dest_o       (dest_o),
  .fixed_set_o  (fixed_set_o),
  .smi_o        (smi_o),
  .nmi_o        (nmi_o),
  .init_o       (init_o),
  .sipi_o       (sipi_o),
  .arb_reload_o (arb_reload_o)
);

// File: tb/sim_ipi_cmd_dispatch.sv
`timescale 1ns/100ps
module sim_ipi_cmd_dispatch;

  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_mode_i = 1'b0;
  logic        wr_lo_i = 1'b0;
  logic        wr_hi_i = 1'b0;
  logic        wr_self_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [2:0]  self_idx_i = '0;
  logic [N-1:0] match_mask_i = '0;
  logic [31:0] dest_o;
  logic        dest_logical_o, busy_o;
  logic [N-1:0] fixed_set_o, smi_o, nmi_o, init_o, sipi_o, arb_reload_o;
  logic [7:0]  vec_o;
  logic        trig_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] hi_shadow = '0;

  always #2.5 clk_i = ~clk_i;

  ipi_cmd_dispatch #(.N_TGT(N)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {fixed, smi, nmi, init, sipi, arb}
  function automatic logic [6*N-1:0] model(input logic [31:0] w, input logic [N-1:0] mt,
                                           input logic [2:0] sid);
    logic [N-1:0] so, m, lo;
    logic [N-1:0] fx, sm, nm, it, sp, ar;
    so = '0; so[sid] = 1'b1;
    case (w[19:18])
      2'd0: m = mt;
      2'd1: m = so;
      2'd2: m = '1;
      default: m = ~so;
    endcase
    lo = '0;
    for (int i = N - 1; i >= 0; i--) if (m[i]) lo = N'(1) << i;
    {fx, sm, nm, it, sp, ar} = '0;
    case (w[10:8])
      3'd0: fx = m;
      3'd1: fx = lo;
      3'd2: sm = m;
      3'd4: nm = m;
      3'd5: if (!w[14] && w[15]) ar = m; else it = m;
      3'd6: sp = m;
      default: ;
    endcase
    return {fx, sm, nm, it, sp, ar};
  endfunction

  task automatic write_hi(input logic [31:0] d);
    @(negedge clk_i);
    wr_hi_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_hi_i = 1'b0;
    hi_shadow = d;
    chk("R2 high write no busy", 64'(busy_o), 64'h0);
  endtask

  task automatic run(input bit self_wr, input logic [31:0] d, input logic [N-1:0] mt,
                     input logic [2:0] sid, input logic ext, input string tag);
    logic [31:0] w;
    bit fires;
    w = self_wr ? (32'h0004_0000 | {24'h0, d[7:0]}) : d;
    fires = !self_wr || ext;
    @(negedge clk_i);
    ext_mode_i = ext; match_mask_i = mt; self_idx_i = sid;
    wr_data_i = d;
    if (self_wr) wr_self_i = 1'b1; else wr_lo_i = 1'b1;
    @(negedge clk_i);
    wr_lo_i = 1'b0; wr_self_i = 1'b0;
    chk({"R2 busy ", tag}, 64'(busy_o), 64'(fires));
    if (fires) begin
      chk({"R3 dest ", tag}, 64'(dest_o), ext ? 64'(hi_shadow) : 64'(hi_shadow[31:24]));
      chk({"R3 dest mode ", tag}, 64'(dest_logical_o), 64'(w[11]));
    end
    @(negedge clk_i);
    chk({tag, " pulses"}, 64'({fixed_set_o, smi_o, nmi_o, init_o, sipi_o, arb_reload_o}),
        fires ? 64'(model(w, mt, sid)) : 64'h0);
    if (fires) chk({"R5 vec/trig ", tag}, 64'({vec_o, trig_o}), 64'({w[7:0], w[15]}));
    chk({"R2 busy drop ", tag}, 64'(busy_o), 64'h0);
    @(negedge clk_i);
    chk({"R13 single pulse ", tag},
        64'({fixed_set_o, smi_o, nmi_o, init_o, sipi_o, arb_reload_o}), 64'h0);
  endtask

  function automatic logic [31:0] cmd(input logic [7:0] v, input logic [2:0] md,
                                      input logic lg, input logic lv, input logic tr,
                                      input logic [1:0] sh);
    return {12'h0, sh, 2'b00, tr, lv, 2'b00, lg, md, v};
  endfunction

  initial begin : main
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    chk("R1 reset busy", 64'(busy_o), 64'h0);
    chk("R1 reset pulses", 64'({fixed_set_o, smi_o, nmi_o, init_o, sipi_o, arb_reload_o}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 64'({busy_o, fixed_set_o, smi_o, nmi_o, init_o, sipi_o, arb_reload_o}), 64'h0);

    write_hi(32'hA5C3_0F17);
    run(0, cmd(8'h31, 3'd0, 1'b1, 1'b1, 1'b0, 2'd0), 8'h5A, 3'd2, 1'b0, "R3 R5 compact fixed");
    run(0, cmd(8'h32, 3'd0, 1'b0, 1'b1, 1'b1, 2'd0), 8'h81, 3'd2, 1'b1, "R3 R5 ext fixed level");
    run(0, cmd(8'h40, 3'd0, 1'b0, 1'b1, 1'b0, 2'd1), 8'h00, 3'd5, 1'b0, "R4 self");
    run(0, cmd(8'h41, 3'd0, 1'b0, 1'b1, 1'b0, 2'd2), 8'h00, 3'd5, 1'b0, "R4 all");
    run(0, cmd(8'h42, 3'd0, 1'b0, 1'b1, 1'b0, 2'd3), 8'h00, 3'd0, 1'b0, "R4 others");
    run(0, cmd(8'h50, 3'd1, 1'b0, 1'b1, 1'b0, 2'd0), 8'h68, 3'd0, 1'b0, "R6 lowest pick");
    run(0, cmd(8'h51, 3'd1, 1'b0, 1'b1, 1'b0, 2'd0), 8'h00, 3'd0, 1'b0, "R6 lowest empty");
    run(0, cmd(8'h52, 3'd1, 1'b0, 1'b1, 1'b0, 2'd3), 8'h00, 3'd0, 1'b0, "R6 lowest others");
    run(0, cmd(8'h00, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0), 8'h0C, 3'd0, 1'b0, "R7 smi");
    run(0, cmd(8'h00, 3'd4, 1'b0, 1'b1, 1'b0, 2'd2), 8'h00, 3'd0, 1'b0, "R7 nmi");
    run(0, cmd(8'h00, 3'd5, 1'b0, 1'b1, 1'b1, 2'd0), 8'hF0, 3'd0, 1'b0, "R8 init assert");
    run(0, cmd(8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0), 8'h0F, 3'd0, 1'b0, "R8 init edge");
    run(0, cmd(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd3), 8'h00, 3'd1, 1'b0, "R9 init deassert");
    run(0, cmd(8'h9A, 3'd6, 1'b0, 1'b1, 1'b0, 2'd0), 8'h22, 3'd0, 1'b0, "R10 startup");
    run(0, cmd(8'h11, 3'd3, 1'b0, 1'b1, 1'b0, 2'd2), 8'hFF, 3'd0, 1'b0, "R11 reserved 3");
    run(0, cmd(8'h12, 3'd7, 1'b0, 1'b1, 1'b0, 2'd2), 8'hFF, 3'd0, 1'b0, "R11 reserved 7");
    run(1, 32'hFFFF_FF77, 8'hFF, 3'd6, 1'b1, "R12 self ext");
    run(1, 32'h0000_0066, 8'hFF, 3'd6, 1'b0, "R12 self compact ignored");

    for (int k = 0; k < 300; k++) begin
      logic [31:0] d;
      if (k % 16 == 0) write_hi($urandom);
      d = $urandom;
      run((k % 9) == 4, d, N'($urandom), 3'($urandom), 1'($urandom), "R13 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule